// File: doc/BRIEF.md
# Interrupt Pin Capture and Dispatcher

This block watches a bank of interrupt input pins and a smaller set of legacy request lines. It records requests in a pending register. For each pin, that pin's redirection entry decides how the request is captured: a level-mode pin mirrors its input, and an edge-mode pin remembers a rising transition until the request is delivered.

A scanner walks the pins from the lowest number upward. For each pending pin whose entry is not masked, it emits one delivery message on a valid/ready channel. The message fields are taken from the pin's entry. For the external-interrupt delivery mode, the scanner first runs a request/acknowledge exchange with a legacy controller and uses the vector that the controller returns.

The redirection table arrives as a flat bus from a register file elsewhere. Each pin owns 64 bits of that bus. The block holds no copy of the table apart from the fields of the message in flight.

Top module: `irq_dispatch`

## Requirements
- R1: A pin whose entry has bit 15 = 1 (level mode) has its pending bit equal to its input level, sampled one clock earlier. It is therefore delivered repeatedly while high, and not at all once low.
- R2: A pin whose entry has bit 15 = 0 (edge mode) becomes pending on a low-to-high transition of its input. A high-to-low transition creates no request.
- R3: A pin whose entry has bit 16 = 1 (masked) produces no message while masked.
- R4: When an edge-mode pin's message is accepted, that pin's pending bit is cleared, so a single edge yields exactly one message. A level-mode pin's pending bit is not cleared by delivery.
- R5: When several pins are pending, their messages leave in ascending pin-number order within a pass.
- R6: While msg_valid is high and msg_ready is low, msg_valid stays high and every message field holds its value.
- R7: When bits 10:8 of the entry equal 7 (external interrupt), ext_vec_req is raised and held until ext_vec_ack. msg_vector then carries the value of ext_vec captured at the acknowledge, not entry bits 7:0. No message is valid while the request is outstanding.
- R8: Legacy line 0 drives pin 2, and does not drive pin 0. Each other legacy line k drives pin k.
- R9: Message fields map from the entry as follows: destination = bits 63:56, destination mode = bit 11, delivery mode = bits 10:8, vector = bits 7:0 (except as set by R7), polarity = bit 13, trigger mode = bit 15. The delivery mode codes are 0 fixed, 1 lowest priority, 2 performance monitor, 4 NMI, 5 INIT and 7 external.
- R10: An edge-mode request captured while its pin is masked stays pending. It is delivered once the mask bit is cleared.
- R11: After reset, msg_valid and ext_vec_req are low and no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NUM_PINS | Interrupt pin levels, synchronous to clk |
| legacy_in | input | NUM_LEGACY | Legacy request line levels, synchronous to clk |
| redir_tbl | input | NUM_PINS*64 | Redirection entries; entry p occupies bits p*64+63 down to p*64 |
| ext_vec_req | output | 1 | Request for a vector from the legacy controller |
| ext_vec_ack | input | 1 | Legacy controller acknowledge; ext_vec is valid with it |
| ext_vec | input | 8 | Vector returned by the legacy controller |
| msg_valid | output | 1 | Delivery message valid |
| msg_ready | input | 1 | Delivery message accepted when high together with msg_valid |
| msg_dest | output | 8 | Destination field |
| msg_dest_mode | output | 1 | Destination mode |
| msg_dmode | output | 3 | Delivery mode code |
| msg_vector | output | 8 | Interrupt vector |
| msg_polarity | output | 1 | Pin polarity bit |
| msg_trigger | output | 1 | Trigger mode, 1 = level |

## Verification
The assertions assume that ext_vec_ack is asserted only while ext_vec_req is high, and that ext_vec is valid in the same clock as the acknowledge. They also assume that pin and legacy levels change only between clock edges.

The bench changes the redirection table only while the scanner is idle or while the pin concerned is not pending. It drives every input at the falling edge, and it pulses the acknowledge for exactly one clock after it has seen the request.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ENTRY_W = 64;
  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;

  // Bit positions within one redirection entry
  localparam int B_DMODE_LO = 8;
  localparam int B_DSTMODE  = 11;
  localparam int B_POL      = 13;
  localparam int B_TRIG     = 15;
  localparam int B_MASK     = 16;
  localparam int B_DEST_LO  = 56;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_PERF   = 3'd2,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_EXTERN = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    SC_IDLE,
    SC_CHECK,
    SC_VREQ,
    SC_SEND
  } scan_state_e;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              dest_mode;
    logic [2:0]        dmode;
    logic [VEC_W-1:0]  vector;
    logic              polarity;
    logic              trigger;
  } msg_t;
endpackage

// File: rtl/irqd_capture.sv
module irqd_capture #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [NUM_PINS-1:0] lvl_mode,
  input  logic [NUM_PINS-1:0] consume,
  output logic [NUM_PINS-1:0] irr
);
  logic [NUM_PINS-1:0] prev_q, prev_d, irr_q, irr_d;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise;
    always_comb begin
      rise      = pin_lvl[p] & ~prev_q[p];
      prev_d[p] = pin_lvl[p];
      if (lvl_mode[p]) irr_d[p] = pin_lvl[p];
      else             irr_d[p] = rise | (irr_q[p] & ~consume[p]);
    end

    // R1: level-mode pending mirrors last cycle's input
    p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(lvl_mode[p]) |-> irr_q[p] == $past(pin_lvl[p]));
    // R2: rising edge in edge mode sets pending
    p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!lvl_mode[p] && pin_lvl[p] && !prev_q[p]) |-> irr_q[p]);
    // R4: delivery consumes an edge request when no new edge coincides
    p_edge_consume_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(!lvl_mode[p] && consume[p] && !(pin_lvl[p] && !prev_q[p]))
      |-> !irr_q[p]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= prev_d;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;
endmodule

// File: rtl/irqd_scanner.sv
module irqd_scanner
  import irqd_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PTR_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         pending,
  input  logic [NUM_PINS*ENTRY_W-1:0] tbl,
  output logic                        ext_vec_req,
  input  logic                        ext_vec_ack,
  input  logic [VEC_W-1:0]            ext_vec,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output msg_t                        msg,
  output logic [NUM_PINS-1:0]         consume
);
  scan_state_e       st_q, st_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  msg_t              msg_q, msg_d;
  logic [ENTRY_W-1:0] ent;
  logic              last_pin;
  logic              unused_bits;

  assign ent         = tbl[int'(ptr_q)*ENTRY_W +: ENTRY_W];
  assign last_pin    = (ptr_q == PTR_W'(NUM_PINS-1));
  assign unused_bits = ^{ent[B_DEST_LO-1:B_MASK], ent[14], ent[12]};

  always_comb begin
    st_d        = st_q;
    ptr_d       = ptr_q;
    msg_d       = msg_q;
    consume     = '0;
    ext_vec_req = 1'b0;
    msg_valid   = 1'b0;
    case (st_q)
      SC_IDLE: if (|pending) begin
        st_d  = SC_CHECK;
        ptr_d = '0;
      end
      SC_CHECK: begin
        if (pending[ptr_q]) begin
          msg_d.dest      = ent[B_DEST_LO +: DEST_W];
          msg_d.dest_mode = ent[B_DSTMODE];
          msg_d.dmode     = ent[B_DMODE_LO +: 3];
          msg_d.vector    = ent[VEC_W-1:0];
          msg_d.polarity  = ent[B_POL];
          msg_d.trigger   = ent[B_TRIG];
          st_d = (ent[B_DMODE_LO +: 3] == DM_EXTERN) ? SC_VREQ : SC_SEND;
        end else if (last_pin) begin
          st_d = SC_IDLE;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end
      SC_VREQ: begin
        ext_vec_req = 1'b1;
        if (ext_vec_ack) begin
          msg_d.vector = ext_vec;
          st_d         = SC_SEND;
        end
      end
      default: begin
        msg_valid = 1'b1;
        if (msg_ready) begin
          consume[ptr_q] = ~msg_q.trigger;
          if (last_pin) st_d = SC_IDLE;
          else begin
            st_d  = SC_CHECK;
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SC_IDLE;
      ptr_q <= '0;
      msg_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      msg_q <= msg_d;
    end
  end

  assign msg = msg_q;

  // R6: a stalled message holds valid and all fields
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg));
  // R7: vector request holds until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_vec_req && !ext_vec_ack |=> ext_vec_req && !msg_valid);
  // R7: acknowledged vector is what goes out
  p_ext_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_vec_req && ext_vec_ack |=> msg_valid && msg.vector == $past(ext_vec));
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int NUM_PINS   = 24,
  parameter int NUM_LEGACY = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         pin_in,
  input  logic [NUM_LEGACY-1:0]       legacy_in,
  input  logic [NUM_PINS*ENTRY_W-1:0] redir_tbl,
  output logic                        ext_vec_req,
  input  logic                        ext_vec_ack,
  input  logic [VEC_W-1:0]            ext_vec,
  output logic                        msg_valid,
  input  logic                        msg_ready,
  output logic [DEST_W-1:0]           msg_dest,
  output logic                        msg_dest_mode,
  output logic [2:0]                  msg_dmode,
  output logic [VEC_W-1:0]            msg_vector,
  output logic                        msg_polarity,
  output logic                        msg_trigger
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [NUM_PINS-1:0] eff_lvl, lvl_mode, masked, irr, consume;
  msg_t                msg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_route
    logic from_legacy;
    if (p == 2 && NUM_LEGACY > 2) begin : g_two
      assign from_legacy = legacy_in[0] | legacy_in[2];
    end else if (p == 2) begin : g_two_only
      assign from_legacy = legacy_in[0];
    end else if (p != 0 && p < NUM_LEGACY) begin : g_same
      assign from_legacy = legacy_in[p];
    end else begin : g_none
      assign from_legacy = 1'b0;
    end
    assign eff_lvl[p]  = pin_in[p] | from_legacy;
    assign lvl_mode[p] = redir_tbl[p*ENTRY_W + B_TRIG];
    assign masked[p]   = redir_tbl[p*ENTRY_W + B_MASK];
  end

  irqd_capture #(.NUM_PINS(NUM_PINS)) u_capture (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pin_lvl  (eff_lvl),
    .lvl_mode (lvl_mode),
    .consume  (consume),
    .irr      (irr)
  );

  irqd_scanner #(.NUM_PINS(NUM_PINS)) u_scanner (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .pending     (irr & ~masked),
    .tbl         (redir_tbl),
    .ext_vec_req (ext_vec_req),
    .ext_vec_ack (ext_vec_ack),
    .ext_vec     (ext_vec),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg         (msg),
    .consume     (consume)
  );

  assign msg_dest      = msg.dest;
  assign msg_dest_mode = msg.dest_mode;
  assign msg_dmode     = msg.dmode;
  assign msg_vector    = msg.vector;
  assign msg_polarity  = msg.polarity;
  assign msg_trigger   = msg.trigger;
endmodule

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb;
  localparam int NP = 24;
  localparam int NL = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NP-1:0] pin_in;
  logic [NL-1:0] legacy_in;
  logic [63:0] ent [NP];
  logic [NP*64-1:0] redir_tbl;
  logic ext_vec_req, ext_vec_ack, msg_valid, msg_ready;
  logic [7:0] ext_vec, msg_dest, msg_vector;
  logic msg_dest_mode, msg_polarity, msg_trigger;
  logic [2:0] msg_dmode;
  int n_tests = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  always_comb for (int i = 0; i < NP; i++) redir_tbl[i*64 +: 64] = ent[i];

  irq_dispatch #(.NUM_PINS(NP), .NUM_LEGACY(NL)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .legacy_in(legacy_in),
    .redir_tbl(redir_tbl), .ext_vec_req(ext_vec_req), .ext_vec_ack(ext_vec_ack),
    .ext_vec(ext_vec), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_dest(msg_dest), .msg_dest_mode(msg_dest_mode), .msg_dmode(msg_dmode),
    .msg_vector(msg_vector), .msg_polarity(msg_polarity), .msg_trigger(msg_trigger));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dm,
      input logic dmm, input logic pol, input logic trig, input logic msk,
      input logic [7:0] dst);
    logic [63:0] e = '0;
    e[7:0] = vec; e[10:8] = dm; e[11] = dmm; e[13] = pol; e[15] = trig;
    e[16] = msk; e[63:56] = dst;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pin_in = '0; legacy_in = '0; ext_vec_ack = 1'b0;
    ext_vec = '0; msg_ready = 1'b1;
    for (int i = 0; i < NP; i++) ent[i] = mk(8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_valid(output bit seen);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (msg_valid) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic count_msgs(input int ncyc, output int cnt);
    cnt = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (msg_valid && msg_ready) cnt++;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(!msg_valid && !ext_vec_req, "R11 reset idle", {msg_valid, ext_vec_req}, 0);
    pin_in = '1;
    ent[5] = mk(8'h55, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    begin int c; count_msgs(5, c);
      chk(c <= 1, "R11 fresh start", c, 1); end
  endtask

  task automatic t_fields_edge();
    int c; bit s;
    do_reset();
    ent[3] = mk(8'h31, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA5);
    msg_ready = 1'b0;
    pin_in[3] = 1'b1;
    wait_valid(s);
    chk(s, "R2 edge request", s, 1);
    chk(msg_vector == 8'h31 && msg_dest == 8'hA5, "R9 vector/dest",
        {msg_dest, msg_vector}, 16'hA531);
    chk(msg_dmode == 3'd4 && msg_dest_mode && msg_polarity && !msg_trigger,
        "R9 mode bits", {msg_dmode, msg_dest_mode, msg_polarity, msg_trigger}, 6'b100110);
    msg_ready = 1'b1;
    @(negedge clk);
    count_msgs(80, c);
    chk(c == 0, "R4 edge consumed", c, 0);
    pin_in[3] = 1'b0;
    count_msgs(80, c);
    chk(c == 0, "R2 falling edge ignored", c, 0);
  endtask

  task automatic t_level();
    int c;
    do_reset();
    ent[7] = mk(8'h70, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02);
    pin_in[7] = 1'b1;
    count_msgs(120, c);
    chk(c >= 2, "R4 level stays pending", c, 2);
    pin_in[7] = 1'b0;
    count_msgs(60, c);
    count_msgs(100, c);
    chk(c == 0, "R1 level low no request", c, 0);
  endtask

  task automatic t_mask();
    int c; bit s;
    do_reset();
    ent[5] = mk(8'h5A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03);
    pin_in[5] = 1'b1;
    count_msgs(80, c);
    chk(c == 0 && !msg_valid, "R3 masked silent", c, 0);
    ent[5][16] = 1'b0;
    wait_valid(s);
    chk(s && msg_vector == 8'h5A, "R10 held edge after unmask", msg_vector, 8'h5A);
  endtask

  task automatic t_order();
    bit s;
    do_reset();
    ent[4] = mk(8'h44, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04);
    ent[9] = mk(8'h99, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h09);
    msg_ready = 1'b0;
    pin_in[4] = 1'b1; pin_in[9] = 1'b1;
    wait_valid(s);
    chk(s && msg_vector == 8'h44, "R5 lower pin first", msg_vector, 8'h44);
    repeat (10) @(negedge clk);
    chk(msg_valid && msg_vector == 8'h44 && msg_dest == 8'h04, "R6 stall hold",
        msg_vector, 8'h44);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    wait_valid(s);
    chk(s && msg_vector == 8'h99, "R5 higher pin second", msg_vector, 8'h99);
    msg_ready = 1'b1;
  endtask

  task automatic t_extint();
    bit s = 0;
    do_reset();
    ent[10] = mk(8'h11, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0A);
    pin_in[10] = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (ext_vec_req) begin s = 1; break; end
      @(negedge clk);
    end
    chk(s, "R7 vector request raised", s, 1);
    repeat (4) @(negedge clk);
    chk(ext_vec_req && !msg_valid, "R7 wait for ack", {ext_vec_req, msg_valid}, 2'b10);
    ext_vec_ack = 1'b1; ext_vec = 8'h77;
    @(negedge clk);
    ext_vec_ack = 1'b0; ext_vec = 8'h00;
    chk(msg_valid && msg_vector == 8'h77 && msg_dmode == 3'd7, "R7 legacy vector",
        msg_vector, 8'h77);
  endtask

  task automatic t_legacy();
    int c; bit s;
    do_reset();
    ent[0] = mk(8'h40, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    legacy_in[0] = 1'b1;
    count_msgs(80, c);
    chk(c == 0, "R8 line0 not pin0", c, 0);
    legacy_in[0] = 1'b0;
    ent[2] = mk(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    msg_ready = 1'b0;
    legacy_in[0] = 1'b1;
    wait_valid(s);
    chk(s && msg_vector == 8'h22, "R8 line0 to pin2", msg_vector, 8'h22);
    msg_ready = 1'b1;
    @(negedge clk);
    ent[6] = mk(8'h66, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
    msg_ready = 1'b0;
    legacy_in[6] = 1'b1;
    wait_valid(s);
    chk(s && msg_vector == 8'h66, "R8 line6 to pin6", msg_vector, 8'h66);
    msg_ready = 1'b1;
  endtask

  initial begin
    t_reset();
    t_fields_edge();
    t_level();
    t_mask();
    t_order();
    t_extint();
    t_legacy();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule